// File: doc/BRIEF.md
# Multi-bank GPIO register controller

This block is the register-side core of a 94-pin general purpose I/O controller. Software reaches it through a 32-bit word-oriented register port, which is a request channel and a response channel, each with a valid/ready handshake. Three kinds of state live behind that port: pin-indexed bitmaps packed 32 pins to a word, one 1-bit interrupt line selector, and two configuration words for every pin.

From the configuration the block drives each pad's output level and output enable. A pin in native mode passes a native-function level through. Every pad input runs through a two-flop synchronizer, and a per-pin sensing disable can force it to zero. The synchronized, gated level is reflected in the first configuration word and is also exported. The separate interrupt detection block takes it, together with the enable bitmap and the line selector.

Back-pressure works as follows. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Exactly one response beat follows in the next cycle. While that beat waits on `rsp_ready`, no further request is accepted.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the following hold. Every pin is native (bit 0 of its first word is 0) and an input (bit 2 of its first word is 1). Sensing is off (bit 2 of its second word is 1) and the pull code is 0. Every interrupt enable is 0. Every ownership bit for pins 0..93 is 1, so the ownership words read 0xFFFFFFFF, 0xFFFFFFFF and 0x3FFFFFFF. The line selector is 0 and no pad output enable is set.
- R2: Pin p's ownership bit is bit p%32 of the word at 0x000 + 4*(p/32). Its interrupt-enable bit is bit p%32 of the word at 0x090 + 4*(p/32). Both are read/write. Bit positions for pins 94 and 95 read 0 and ignore writes. The ownership and enable bitmaps also appear on `own_map` and `irq_en`.
- R3: Pin p's first word is at 0x100 + 8*p: bit 31 is the output level, bit 2 the direction (1 input, 0 output) and bit 0 the function (1 GPIO, 0 native). Its second word is at 0x104 + 8*p: bit 2 disables sensing and bits 1:0 hold the pull code. All other bits read 0, and bit 30 is read-only.
- R4: `pad_oe[p]` is 1 exactly when the function bit is 1 and the direction bit is 0. `pad_out[p]` is the output-level bit in GPIO mode and `native_out[p]` in native mode.
- R5: While sensing is enabled for pin p, `sense_lvl[p]` and bit 30 of its first word show `pad_in[p]` delayed by two clock edges. While sensing is disabled, both read 0.
- R6: Bit 0 of the word at 0x07C holds the interrupt line selector, shown on `irq_line_sel`. Its other bits read 0.
- R7: The following read 0 and ignore writes: any offset not named above, configuration words of pins 94 and up (0x3F0..0x3FF), and any address whose two low bits are not 00.
- R8: `req_ready` = !`rsp_valid` | `rsp_ready`. An accepted request gives `rsp_valid` in the next cycle. A write takes effect on its accepting edge and its response data is 0. A read returns the state at its accepting edge. A response waiting on `rsp_ready` keeps `rsp_valid` and `rsp_rdata` unchanged.
- R9: `pull_sel[2p+1:2p]` shows pin p's pull code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response beat consumed |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| pad_in | input | 94 | Raw pad input levels |
| native_out | input | 94 | Native-function output levels |
| pad_out | output | 94 | Pad output levels |
| pad_oe | output | 94 | Pad output enables |
| sense_lvl | output | 94 | Synchronized, gated input levels |
| irq_en | output | 94 | Interrupt-enable bitmap |
| irq_line_sel | output | 1 | Upstream interrupt line choice |
| own_map | output | 94 | Ownership bitmap |
| pull_sel | output | 188 | Two-bit pull code per pin |

## Verification
The response-hold property assumes the requester keeps `req_*` steady while `req_valid` is high and `req_ready` is low. The bench changes those inputs only on the falling clock edge and keeps them steady through every stall. The sensing-latency property compares against `pad_in` as sampled on the rising edge, so it assumes the pads change away from that edge. The bench drives pads on falling edges and holds reset long enough for the synchronizer history to be defined.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned DEF_PINS   = 94;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DEF_ADDR_W = 12;

  // byte offsets of the register groups
  localparam int unsigned OWN_OFF  = 32'h000;
  localparam int unsigned LSEL_OFF = 32'h07C;
  localparam int unsigned IEN_OFF  = 32'h090;
  localparam int unsigned CFG_OFF  = 32'h100;

  // field positions inside the per-pin words
  localparam int unsigned C1_OUT = 31;
  localparam int unsigned C1_IN  = 30;
  localparam int unsigned C1_DIR = 2;
  localparam int unsigned C1_SEL = 0;
  localparam int unsigned C2_DIS = 2;

  function automatic int unsigned words_for(int unsigned nbits);
    return (nbits + WORD_W - 1) / WORD_W;
  endfunction

  typedef struct packed {
    logic       out_lvl;
    logic       dir_in;
    logic       gpio_sel;
    logic       sense_dis;
    logic [1:0] pull;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_reg_port.sv
module gpio_reg_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  input  logic [DW-1:0] rd_next,
  output logic [DW-1:0] rsp_rdata,
  output logic          accept
);
  logic          rsp_valid_q;
  logic [DW-1:0] rdata_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rdata_q     <= rd_next;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R8
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
endmodule

// File: rtl/gpio_bitmap_bank.sv
module gpio_bitmap_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BITS = DEF_PINS,
  parameter logic        RST_VAL  = 1'b0,
  localparam int unsigned NWORDS  = words_for(NUM_BITS),
  localparam int unsigned IDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    word_idx,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [NUM_BITS-1:0] bits,
  output logic [WORD_W-1:0]   rd_data
);
  logic [NUM_BITS-1:0]        bits_q;
  logic [NWORDS*WORD_W-1:0]   padded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= {NUM_BITS{RST_VAL}};
    end else if (wr_en) begin
      for (int b = 0; b < int'(NUM_BITS); b++) begin
        if (int'(word_idx) == b / int'(WORD_W))
          bits_q[b] <= wr_data[b % int'(WORD_W)];
      end
    end
  end

  assign padded = {{(NWORDS*WORD_W-NUM_BITS){1'b0}}, bits_q};

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < int'(NWORDS); w++) begin
      if (int'(word_idx) == w) rd_data = padded[w*WORD_W +: WORD_W];
    end
  end

  assign bits = bits_q;

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits_q));
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_c1,
  input  logic              wr_c2,
  input  logic              wd_out,
  input  logic              wd_dir,
  input  logic              wd_sel,
  input  logic              wd_dis,
  input  logic [1:0]        wd_pull,
  input  logic              pad_in,
  input  logic              native_out,
  output logic [WORD_W-1:0] c1_rd,
  output logic [WORD_W-1:0] c2_rd,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              sensed,
  output logic [1:0]        pull
);
  pin_cfg_t cfg_q;
  logic     sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{out_lvl: 1'b0, dir_in: 1'b1, gpio_sel: 1'b0,
                 sense_dis: 1'b1, pull: 2'b00};
    end else begin
      if (wr_c1) begin
        cfg_q.out_lvl  <= wd_out;
        cfg_q.dir_in   <= wd_dir;
        cfg_q.gpio_sel <= wd_sel;
      end
      if (wr_c2) begin
        cfg_q.sense_dis <= wd_dis;
        cfg_q.pull      <= wd_pull;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign sensed  = sync2_q && !cfg_q.sense_dis;
  assign pad_oe  = cfg_q.gpio_sel && !cfg_q.dir_in;
  assign pad_out = cfg_q.gpio_sel ? cfg_q.out_lvl : native_out;
  assign pull    = cfg_q.pull;

  always_comb begin
    c1_rd         = '0;
    c1_rd[C1_OUT] = cfg_q.out_lvl;
    c1_rd[C1_IN]  = sensed;
    c1_rd[C1_DIR] = cfg_q.dir_in;
    c1_rd[C1_SEL] = cfg_q.gpio_sel;
    c2_rd         = '0;
    c2_rd[C2_DIS] = cfg_q.sense_dis;
    c2_rd[1:0]    = cfg_q.pull;
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c1 && !wr_c2 |=> $stable(cfg_q));

  // R5
  sense_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.sense_dis && $past(!cfg_q.sense_dis) |-> sensed == $past(pad_in, 2));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_PINS = DEF_PINS,
  parameter int unsigned ADDR_W   = DEF_ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [WORD_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [WORD_W-1:0]     rsp_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  input  logic [NUM_PINS-1:0]   native_out,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   sense_lvl,
  output logic [NUM_PINS-1:0]   irq_en,
  output logic                  irq_line_sel,
  output logic [NUM_PINS-1:0]   own_map,
  output logic [2*NUM_PINS-1:0] pull_sel
);
  localparam int unsigned NWORDS = words_for(NUM_PINS);
  localparam int unsigned IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int unsigned PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int unsigned WA_W   = ADDR_W - 2;
  localparam int unsigned OWN_W0 = OWN_OFF / 4;
  localparam int unsigned IEN_W0 = IEN_OFF / 4;
  localparam int unsigned LSEL_W = LSEL_OFF / 4;
  localparam int unsigned CFG_W0 = CFG_OFF / 4;

  // ---------------- address decode ----------------
  logic [WA_W-1:0]  waddr, own_rel, ien_rel, cfg_rel;
  logic             aligned, own_hit, ien_hit, lsel_hit, cfg_hit, any_hit;
  logic [PIN_W-1:0] pin_idx;

  assign waddr    = req_addr[ADDR_W-1:2];
  assign aligned  = (req_addr[1:0] == 2'b00);
  assign own_rel  = waddr - WA_W'(OWN_W0);
  assign ien_rel  = waddr - WA_W'(IEN_W0);
  assign cfg_rel  = waddr - WA_W'(CFG_W0);
  assign own_hit  = aligned && (own_rel < WA_W'(NWORDS));
  assign ien_hit  = aligned && (ien_rel < WA_W'(NWORDS));
  assign lsel_hit = aligned && (waddr == WA_W'(LSEL_W));
  assign cfg_hit  = aligned && (cfg_rel < WA_W'(2*NUM_PINS));
  assign any_hit  = own_hit || ien_hit || lsel_hit || cfg_hit;
  assign pin_idx  = cfg_rel[PIN_W:1];

  // ---------------- register port ----------------
  logic              accept, wr_acc;
  logic [WORD_W-1:0] rd_next;

  gpio_reg_port #(.DW(WORD_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rd_next   (rd_next),
    .rsp_rdata (rsp_rdata),
    .accept    (accept)
  );

  assign wr_acc = accept && req_write;

  // ---------------- bitmap banks ----------------
  logic [WORD_W-1:0] own_rd, ien_rd;

  gpio_bitmap_bank #(.NUM_BITS(NUM_PINS), .RST_VAL(1'b1)) u_own (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_idx (own_rel[IDX_W-1:0]),
    .wr_en    (wr_acc && own_hit),
    .wr_data  (req_wdata),
    .bits     (own_map),
    .rd_data  (own_rd)
  );

  gpio_bitmap_bank #(.NUM_BITS(NUM_PINS), .RST_VAL(1'b0)) u_ien (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_idx (ien_rel[IDX_W-1:0]),
    .wr_en    (wr_acc && ien_hit),
    .wr_data  (req_wdata),
    .bits     (irq_en),
    .rd_data  (ien_rd)
  );

  // ---------------- line selector ----------------
  logic line_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  line_sel_q <= 1'b0;
    else if (wr_acc && lsel_hit) line_sel_q <= req_wdata[0];
  end

  assign irq_line_sel = line_sel_q;

  // ---------------- per-pin cells ----------------
  logic [WORD_W-1:0] c1_rd [NUM_PINS];
  logic [WORD_W-1:0] c2_rd [NUM_PINS];

  for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_pin
    logic sel_me;
    assign sel_me = wr_acc && cfg_hit && (pin_idx == PIN_W'(p));

    gpio_pin_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_c1      (sel_me && !cfg_rel[0]),
      .wr_c2      (sel_me && cfg_rel[0]),
      .wd_out     (req_wdata[C1_OUT]),
      .wd_dir     (req_wdata[C1_DIR]),
      .wd_sel     (req_wdata[C1_SEL]),
      .wd_dis     (req_wdata[C2_DIS]),
      .wd_pull    (req_wdata[1:0]),
      .pad_in     (pad_in[p]),
      .native_out (native_out[p]),
      .c1_rd      (c1_rd[p]),
      .c2_rd      (c2_rd[p]),
      .pad_out    (pad_out[p]),
      .pad_oe     (pad_oe[p]),
      .sensed     (sense_lvl[p]),
      .pull       (pull_sel[2*p +: 2])
    );
  end

  // ---------------- read mux ----------------
  always_comb begin
    rd_next = '0;
    if (!req_write) begin
      if (own_hit)       rd_next = own_rd;
      else if (ien_hit)  rd_next = ien_rd;
      else if (lsel_hit) rd_next = {{(WORD_W-1){1'b0}}, line_sel_q};
      else if (cfg_hit)  rd_next = cfg_rel[0] ? c2_rd[pin_idx] : c1_rd[pin_idx];
    end
  end

  // tracks whether the pending response must carry zero data
  logic zero_rsp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      zero_rsp_q <= 1'b1;
    else if (accept) zero_rsp_q <= req_write || !any_hit;
  end

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && zero_rsp_q |-> rsp_rdata == '0);
endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP         = 94;
  localparam int WD_CYCLES  = 50000;
  localparam int NV         = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, irq_line_sel;
  logic [31:0]   rsp_rdata;
  logic [NP-1:0] pad_in = '0, native_out = '0;
  logic [NP-1:0] pad_out, pad_oe, sense_lvl, irq_en, own_map;
  logic [2*NP-1:0] pull_sel;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  gpio_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .native_out(native_out),
    .pad_out(pad_out), .pad_oe(pad_oe), .sense_lvl(sense_lvl),
    .irq_en(irq_en), .irq_line_sel(irq_line_sel), .own_map(own_map),
    .pull_sel(pull_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {write, addr, wdata, expected response, requirement number}
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'hFFFF0000, 32'h0,        4'd2},  // R2 ownership word 0
    {1'b0, 12'h000, 32'h0,        32'hFFFF0000, 4'd2},
    {1'b1, 12'h008, 32'hFFFFFFFF, 32'h0,        4'd2},  // R2 pins 94/95 stay 0
    {1'b0, 12'h008, 32'h0,        32'h3FFFFFFF, 4'd2},
    {1'b1, 12'h094, 32'h80000001, 32'h0,        4'd2},  // R2 enable word 1
    {1'b0, 12'h094, 32'h0,        32'h80000001, 4'd2},
    {1'b1, 12'h098, 32'hC0000002, 32'h0,        4'd2},
    {1'b0, 12'h098, 32'h0,        32'h00000002, 4'd2},
    {1'b1, 12'h128, 32'hFFFFFFFF, 32'h0,        4'd3},  // R3 pin 5 word 1
    {1'b0, 12'h128, 32'h0,        32'h80000005, 4'd3},
    {1'b1, 12'h12C, 32'hFFFFFFFF, 32'h0,        4'd3},  // R3 pin 5 word 2
    {1'b0, 12'h12C, 32'h0,        32'h00000007, 4'd3},
    {1'b1, 12'h3E8, 32'h80000001, 32'h0,        4'd3},  // R3 pin 93
    {1'b0, 12'h3E8, 32'h0,        32'h80000001, 4'd3},
    {1'b1, 12'h07C, 32'hFFFFFFFF, 32'h0,        4'd6},  // R6
    {1'b0, 12'h07C, 32'h0,        32'h00000001, 4'd6},
    {1'b1, 12'h3F0, 32'hFFFFFFFF, 32'h0,        4'd7},  // R7 pin 94 absent
    {1'b0, 12'h3F0, 32'h0,        32'h0,        4'd7},
    {1'b0, 12'h3F4, 32'h0,        32'h0,        4'd7},
    {1'b0, 12'h3E8, 32'h0,        32'h80000001, 4'd7},
    {1'b1, 12'h040, 32'hFFFFFFFF, 32'h0,        4'd7},
    {1'b0, 12'h040, 32'h0,        32'h0,        4'd7},
    {1'b0, 12'h00C, 32'h0,        32'h0,        4'd7},
    {1'b0, 12'h09C, 32'h0,        32'h0,        4'd7},
    {1'b1, 12'h400, 32'hFFFFFFFF, 32'h0,        4'd7},
    {1'b0, 12'h400, 32'h0,        32'h0,        4'd7},
    {1'b0, 12'h101, 32'h0,        32'h0,        4'd7},  // misaligned
    {1'b1, 12'h07C, 32'h0,        32'h0,        4'd6},
    {1'b0, 12'h07C, 32'h0,        32'h0,        4'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // starts and ends on a falling edge
  task automatic xfer(input bit w, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [80:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", {31'd0, |pad_oe}, 32'd0);
    xfer(0, 12'h000, 0, rd); check("R1 own0", rd, 32'hFFFFFFFF);
    xfer(0, 12'h008, 0, rd); check("R1 own2", rd, 32'h3FFFFFFF);
    xfer(0, 12'h090, 0, rd); check("R1 ien0", rd, 32'h0);
    xfer(0, 12'h100, 0, rd); check("R1 cfg1", rd, 32'h00000004);
    xfer(0, 12'h104, 0, rd); check("R1 cfg2", rd, 32'h00000004);
    xfer(0, 12'h07C, 0, rd); check("R1 lsel", rd, 32'h0);

    // table walk (write responses must be 0, R8)
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      xfer(v[80], v[79:68], v[67:36], rd);
      check($sformatf("R%0d vec%0d", v[3:0], i), rd, v[35:4]);
    end

    // R2 bitmap outputs
    check("R2 ien bits", {28'd0, irq_en[65], irq_en[64], irq_en[63], irq_en[32]}, 32'h0000000B);
    check("R2 own low", own_map[31:0], 32'hFFFF0000);
    // R9 pull output
    check("R9 pull5", {30'd0, pull_sel[11:10]}, 32'd3);
    // R4 pins 93 and 5
    check("R4 pin93", {30'd0, pad_oe[93], pad_out[93]}, 32'd3);
    check("R4 pin5 oe", {31'd0, pad_oe[5]}, 32'd0);

    // R4 output control on pin 0
    xfer(1, 12'h100, 32'h00000001, rd);
    check("R4 gpio out0", {30'd0, pad_oe[0], pad_out[0]}, 32'd2);
    native_out[0] = 1'b1; @(negedge clk);
    check("R4 native ignored", {31'd0, pad_out[0]}, 32'd0);
    xfer(1, 12'h100, 32'h80000001, rd);
    check("R4 gpio out1", {30'd0, pad_oe[0], pad_out[0]}, 32'd3);
    xfer(1, 12'h100, 32'h00000000, rd);
    check("R4 native pass", {30'd0, pad_oe[0], pad_out[0]}, 32'd1);
    native_out[0] = 1'b0; @(negedge clk);
    check("R4 native low", {31'd0, pad_out[0]}, 32'd0);

    // R5 sensing on pin 7
    pad_in[7] = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 gated lvl", {31'd0, sense_lvl[7]}, 32'd0);
    xfer(0, 12'h138, 0, rd); check("R5 gated read", rd, 32'h00000004);
    xfer(1, 12'h13C, 32'h0, rd);
    check("R5 enabled lvl", {31'd0, sense_lvl[7]}, 32'd1);
    xfer(0, 12'h138, 0, rd); check("R5 enabled read", rd, 32'h40000004);
    pad_in[7] = 1'b0;
    @(negedge clk);
    check("R5 one edge", {31'd0, sense_lvl[7]}, 32'd1);
    @(negedge clk);
    check("R5 two edges", {31'd0, sense_lvl[7]}, 32'd0);

    // R8 back-pressure
    rsp_ready = 1'b0;
    xfer(0, 12'h098, 0, rd);
    check("R8 rsp valid", {31'd0, rsp_valid}, 32'd1);
    check("R8 not ready", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h07C; req_wdata = 32'h1;
    repeat (2) @(negedge clk);
    check("R8 held data", rsp_rdata, 32'h00000002);
    check("R8 stall no write", {31'd0, irq_line_sel}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 write taken", {30'd0, rsp_valid, irq_line_sel}, 32'd3);
    check("R8 write rsp zero", rsp_rdata, 32'h0);
    @(negedge clk);
    check("R8 drained", {31'd0, rsp_valid}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule